// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block sits next to a processor's commit stage and enforces forward-edge control-flow integrity. It receives one retired instruction per cycle. Each instruction comes with its address, its 32-bit encoding, a flag that marks it as a register-indirect jump or call, the index of its source register, and the current value of register x7. An indirect transfer through an ordinary register puts the block into a "pad expected" state. The next instruction to retire must then be a correctly placed landing pad. If it is not, the block reports a software-check exception.

A landing pad is an AUIPC whose destination is x0, so it has no architectural effect. Its upper 20 bits hold a label. When that label is nonzero, it must match bits [31:12] of x7, which the caller loads with a hash of the function signature. Indirect transfers through x1 or x5 count as returns. Transfers through x7 count as software-guarded far jumps. Neither kind needs a pad. A single enable input switches the whole check on or off.

Top module: `lpad_guard`

## Requirements
- R1: With enable high, a retired indirect transfer whose source register is not 1, 5 or 7 arms the pad-expected state. If the next retired instruction is not a landing pad, a trap is reported.
- R2: An indirect transfer through register 1 or 5 does not arm the state, and a non-pad after it raises no trap.
- R3: An indirect transfer through register 7 does not arm the state, and a non-pad after it raises no trap.
- R4: A landing pad has bits [6:0] = 7'b0010111 and bits [11:7] = 0. An AUIPC with any other destination is not a pad and faults when a pad is expected.
- R5: An expected landing pad whose address has bits [1:0] not equal to 0 faults.
- R6: The label is bits [31:12] of the pad. A zero label skips the comparison. A nonzero label must equal bits [31:12] of x7, or the pad faults.
- R7: A fault gives a one-cycle trap_valid pulse in the cycle after the faulting instruction retires. In the same cycle, trap_pc holds that instruction's address, trap_cause holds 18 and trap_tval holds 2.
- R8: The armed state lasts through cycles with no retirement. It is cleared by the next retirement, whether that instruction passes or faults. A faulting instruction never arms the state, so a second non-pad after a fault does not trap.
- R9: While enable is low, nothing arms and nothing traps. Driving enable low while the state is armed discards that state.
- R10: Synchronous reset clears the armed state and trap_valid.
- R11: An instruction that retires while the state is not armed never traps, even a misaligned pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Turns landing-pad enforcement on |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | Address of the retiring instruction |
| ret_insn | input | 32 | Encoding of the retiring instruction |
| ret_is_indirect | input | 1 | Retiring instruction is a register-indirect jump or call |
| ret_rs1 | input | 5 | Source register index of the indirect transfer |
| ret_x7 | input | XLEN | Current value of register x7 |
| trap_valid | output | 1 | One-cycle software-check exception pulse |
| trap_pc | output | XLEN | Address of the faulting instruction |
| trap_cause | output | XLEN | Exception cause (18) |
| trap_tval | output | XLEN | Trap value (2) |

## Verification
The armed state changes at the clock edge on which the indirect transfer retires. A trap appears on the outputs exactly one edge after the instruction that caused it, because the trap outputs are the only register between the inputs and the ports. The bench drives one instruction on each falling edge. At the next falling edge it compares trap_valid, and the PC, cause and value that come with it, against a behavioural model that was updated with the previous stimulus. Runs of idle cycles, enable changes and a reset placed between a jump and its successor check that the armed state lasts and is cleared exactly when the requirements say.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   localparam logic [6:0] OPC_AUIPC = 7'b0010111;
   localparam int unsigned LABEL_W = 20;

   typedef struct packed {
      logic               is_pad;
      logic [LABEL_W-1:0] label;
   } pad_info_t;

   function automatic logic rs1_exempt(input logic [4:0] idx);
      return (idx == 5'd1) || (idx == 5'd5) || (idx == 5'd7);
   endfunction
endpackage

// File: rtl/lpg_classify.sv
module lpg_classify
   import lpg_pkg::*;
(
   input  logic [31:0] insn,
   input  logic        is_indirect,
   input  logic [4:0]  rs1,
   output logic        tracked,
   output pad_info_t   pad
);
   assign tracked    = is_indirect && !rs1_exempt(rs1);
   assign pad.is_pad = (insn[6:0] == OPC_AUIPC) && (insn[11:7] == 5'd0);
   assign pad.label  = insn[31:12];
endmodule

// File: rtl/lpg_verdict.sv
module lpg_verdict
   import lpg_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter bit          LABEL_CHECK = 1'b1
) (
   input  pad_info_t        pad,
   input  logic [1:0]       pc_low,
   input  logic [XLEN-1:0]  x7,
   output logic             fault
);
   logic label_bad;

   generate
      if (LABEL_CHECK) begin : g_label
         assign label_bad = (pad.label != '0) && (pad.label != x7[31:12]);
      end else begin : g_nolabel
         assign label_bad = 1'b0;
      end
   endgenerate

   assign fault = !pad.is_pad || (pc_low != 2'b00) || label_bad;
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
   import lpg_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter bit          LABEL_CHECK = 1'b1,
   parameter int unsigned CAUSE_CODE  = 18,
   parameter int unsigned TVAL_CODE   = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            enable,
   input  logic            ret_valid,
   input  logic [XLEN-1:0] ret_pc,
   input  logic [31:0]     ret_insn,
   input  logic            ret_is_indirect,
   input  logic [4:0]      ret_rs1,
   input  logic [XLEN-1:0] ret_x7,
   output logic            trap_valid,
   output logic [XLEN-1:0] trap_pc,
   output logic [XLEN-1:0] trap_cause,
   output logic [XLEN-1:0] trap_tval
);
   localparam logic [XLEN-1:0] CAUSE_V = XLEN'(CAUSE_CODE);
   localparam logic [XLEN-1:0] TVAL_V  = XLEN'(TVAL_CODE);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("lpad_guard: XLEN must be 32 or 64");
      end
   endgenerate

   logic      armed_q;
   logic      tracked;
   logic      fault;
   logic      violate;
   pad_info_t pad;

   lpg_classify u_classify (
      .insn        (ret_insn),
      .is_indirect (ret_is_indirect),
      .rs1         (ret_rs1),
      .tracked     (tracked),
      .pad         (pad)
   );

   lpg_verdict #(.XLEN(XLEN), .LABEL_CHECK(LABEL_CHECK)) u_verdict (
      .pad    (pad),
      .pc_low (ret_pc[1:0]),
      .x7     (ret_x7),
      .fault  (fault)
   );

   assign violate = enable && ret_valid && armed_q && fault;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q    <= 1'b0;
         trap_valid <= 1'b0;
         trap_pc    <= '0;
         trap_cause <= '0;
         trap_tval  <= '0;
      end else begin
         trap_valid <= violate;
         if (violate) begin
            trap_pc    <= ret_pc;
            trap_cause <= CAUSE_V;
            trap_tval  <= TVAL_V;
         end
         if (!enable)        armed_q <= 1'b0;
         else if (ret_valid) armed_q <= tracked && !violate;
      end
   end

   // R7: the trap pulse lasts one cycle and carries fixed codes
   p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      trap_valid |=> !trap_valid);
   p_codes_r7: assert property (@(posedge clk) disable iff (rst)
      trap_valid |-> (trap_cause == CAUSE_V) && (trap_tval == TVAL_V));
   // R9: a low enable suppresses traps
   p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !enable |=> !trap_valid);
   // R11: no trap without a retirement
   p_retire_r11: assert property (@(posedge clk) disable iff (rst)
      !ret_valid |=> !trap_valid);
   // R2/R3: exempt transfers leave the state unarmed
   p_exempt_r2: assert property (@(posedge clk) disable iff (rst)
      (ret_valid && ret_is_indirect && rs1_exempt(ret_rs1)) |=> !armed_q);
   // R8: armed state persists through idle cycles
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (armed_q && enable && !ret_valid) |=> armed_q);
endmodule

// File: tb/lpad_guard_tb.sv
module lpad_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enable = 1'b0;
   logic        ret_valid = 1'b0;
   logic [31:0] ret_pc = '0;
   logic [31:0] ret_insn = '0;
   logic        ret_is_indirect = 1'b0;
   logic [4:0]  ret_rs1 = '0;
   logic [31:0] ret_x7 = '0;
   logic        trap_valid;
   logic [31:0] trap_pc, trap_cause, trap_tval;

   always #5 clk = ~clk;

   lpad_guard #(.XLEN(32)) dut_i (
      .clk(clk), .rst(rst), .enable(enable), .ret_valid(ret_valid),
      .ret_pc(ret_pc), .ret_insn(ret_insn), .ret_is_indirect(ret_is_indirect),
      .ret_rs1(ret_rs1), .ret_x7(ret_x7), .trap_valid(trap_valid),
      .trap_pc(trap_pc), .trap_cause(trap_cause), .trap_tval(trap_tval)
   );

   int    compared = 0;
   int    mismatched = 0;
   bit    finished = 0;
   bit    m_arm = 0;
   bit    exp_trap = 0;
   logic [31:0] exp_pc = '0;
   string last_tag = "R10";

   localparam logic [31:0] NOP = 32'h0000_0013;

   function automatic logic [31:0] pad_op(input logic [19:0] lab);
      return {lab, 5'd0, 7'b0010111};
   endfunction
   function automatic logic [31:0] jalr_op(input logic [4:0] r);
      return {12'd0, r, 3'b000, 5'd0, 7'b1100111};
   endfunction

   task automatic compare_now();
      compared++;
      if (trap_valid !== exp_trap) begin
         mismatched++;
         $display("FAIL %s: trap_valid actual %0b expected %0b", last_tag, trap_valid, exp_trap);
      end else if (exp_trap && (trap_pc !== exp_pc || trap_cause !== 32'd18 || trap_tval !== 32'd2)) begin
         mismatched++;
         $display("FAIL %s: pc/cause/tval actual %h/%0d/%0d expected %h/18/2",
                  last_tag, trap_pc, trap_cause, trap_tval, exp_pc);
      end
   endtask

   // One cycle: check the previous cycle's result, then drive and model this one
   task automatic step(input string tag, input bit r, input bit en, input bit v,
                       input logic [31:0] pc, input logic [31:0] insn,
                       input bit ind, input logic [4:0] rs, input logic [31:0] x7);
      bit is_pad, bad;
      @(negedge clk);
      compare_now();
      rst = r; enable = en; ret_valid = v; ret_pc = pc; ret_insn = insn;
      ret_is_indirect = ind; ret_rs1 = rs; ret_x7 = x7;
      last_tag = tag;
      is_pad = (insn[6:0] == 7'b0010111) && (insn[11:7] == 5'd0);
      bad = !is_pad || (pc[1:0] != 2'b00) ||
            ((insn[31:12] != 20'd0) && (insn[31:12] != x7[31:12]));
      if (r) begin
         m_arm = 0; exp_trap = 0;
      end else begin
         exp_trap = en && v && m_arm && bad;
         if (exp_trap) exp_pc = pc;
         if (!en) m_arm = 0;
         else if (v) m_arm = ind && !(rs == 5'd1 || rs == 5'd5 || rs == 5'd7) && !exp_trap;
      end
   endtask

   task automatic jump(input string tag, input logic [4:0] rs);
      step(tag, 0, 1, 1, 32'h0000_1000, jalr_op(rs), 1, rs, 32'h0);
   endtask
   task automatic next(input string tag, input logic [31:0] pc, input logic [31:0] insn,
                       input logic [31:0] x7);
      step(tag, 0, 1, 1, pc, insn, 0, 5'd0, x7);
   endtask

   initial begin
      step("R10", 1, 0, 0, 0, NOP, 0, 0, 0);
      step("R10", 1, 1, 0, 0, NOP, 0, 0, 0);
      step("R11", 0, 1, 0, 0, NOP, 0, 0, 0);
      jump("R1", 5'd10); next("R1", 32'h2000, pad_op(20'd0), 0);
      jump("R1", 5'd10); next("R7", 32'h2004, NOP, 0);
      next("R8", 32'h2008, NOP, 0);
      jump("R2", 5'd1);  next("R2", 32'h200c, NOP, 0);
      jump("R2", 5'd5);  next("R2", 32'h2010, NOP, 0);
      jump("R3", 5'd7);  next("R3", 32'h2014, NOP, 0);
      jump("R4", 5'd12); next("R4", 32'h2018, {20'd0, 5'd3, 7'b0010111}, 0);
      jump("R5", 5'd12); next("R5", 32'h2022, pad_op(20'd0), 0);
      jump("R6", 5'd11); next("R6", 32'h2024, pad_op(20'h12345), 32'h1234_5abc);
      jump("R6", 5'd11); next("R6", 32'h2028, pad_op(20'h12345), 32'h1234_6000);
      jump("R7", 5'd9);  jump("R7", 5'd9);
      jump("R8", 5'd13);
      step("R8", 0, 1, 0, 0, NOP, 0, 0, 0);
      step("R8", 0, 1, 0, 0, NOP, 0, 0, 0);
      next("R8", 32'h2030, NOP, 0);
      step("R9", 0, 0, 1, 32'h1000, jalr_op(5'd10), 1, 5'd10, 0);
      step("R9", 0, 0, 1, 32'h2034, NOP, 0, 0, 0);
      jump("R9", 5'd10);
      step("R9", 0, 0, 0, 0, NOP, 0, 0, 0);
      next("R9", 32'h2038, NOP, 0);
      jump("R10", 5'd10);
      step("R10", 1, 1, 0, 0, NOP, 0, 0, 0);
      next("R10", 32'h203c, NOP, 0);
      next("R11", 32'h2042, pad_op(20'h1), 0);
      next("R11", 32'h2044, NOP, 0);
      step("R11", 0, 1, 0, 0, NOP, 0, 0, 0);
      step("R11", 0, 1, 0, 0, NOP, 0, 0, 0);
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         compared++; mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule